// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel. It works through a chain of transfer descriptors that software has built in memory. Software writes the address of the first descriptor into the channel's descriptor pointer and then sets the run bit in the control word. The channel then loops through three steps for each descriptor. It reads the four descriptor words. It copies the requested number of bytes from the source region to the destination region, one data word per beat. It then follows the link to the next descriptor. The walk ends after the descriptor whose link word carries the terminate flag.

Completion events are recorded in a status word. Each event bit is cleared by writing a one to it. The events are:
- a descriptor finished;
- the whole chain finished;
- a memory error occurred;
- a descriptor had a zero byte count.

The status word also shows two live flags, busy and halted. A single level interrupt is raised from the event bits, and each class of event has its own enable. Software can stop a running chain in two ways: by dropping the run bit or by writing the abort request. In both cases the channel ends up halted. The run bit is never cleared by hardware. To launch a new chain, software must drop the run bit and then set it again.

The register bus has four word registers, selected by `regAddr`:
- 0: control;
- 1: status;
- 2: descriptor pointer;
- 3: bytes remaining.

Reads are combinational. Writes take effect at the clock edge. The memory port makes one word access at a time. The address and data are held until the memory answers with `memAck`; `memErr` is sampled together with `memAck`.

Top module: `linkdma_chan`

## Requirements
- R1: A descriptor sits at a 32-byte aligned address and holds four words: byte count at +0, source address at +4, destination address at +8 and link word at +12. Bit 0 of the link word is the terminate flag. The low 5 bits of the link are ignored when it is followed.
- R2: A chain is launched only by a 0-to-1 change of control bit 0 (run) while the channel is idle. The run bit still reads 1 after the chain finishes. Writing 1 to an already set run bit starts nothing.
- R3: Data moves one 32-bit word per beat: a read from the source, then a write of that word to the destination. Both addresses step by 4. The remaining count drops by 4, or by the remainder on the last beat, and register 3 reads 0 once the descriptor is done.
- R4: Links are followed until a descriptor with the terminate flag completes. Status bit 1 is set at the end of every descriptor, status bit 0 is set when the chain ends, and busy then drops.
- R5: A descriptor with a byte count of 0 makes no data access. It sets status bit 5 (zero-length error), register 3 reads 0, and the chain continues through its link.
- R6: A memory error on any access sets status bit 4 (transfer error) and status bit 3 (halted), and the channel goes idle.
- R7: Writing control bit 1 (abort request, which reads back 0) stops a running channel at once. Clearing the run bit stops it within two cycles. Either way the channel is left halted, not busy, and makes no further memory access.
- R8: Status bits 0, 1, 4 and 5 are cleared by writing 1 to them. Bit 2 (busy) and bit 3 (halted) are read-only, and halted clears when a new chain launches. After reset, status reads 0.
- R9: `irq` is the OR of three terms: control bit 2 with status bits 4 or 5, control bit 3 with status bit 0, and control bit 4 with status bit 1.
- R10: The descriptor pointer can be written only while the channel is idle, and its low 5 bits read 0. After a chain ends it holds the address of the last descriptor fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data (combinational) |
| memReq | output | 1 | Memory access request, held until acknowledged |
| memWe | output | 1 | Access is a write |
| memAddr | output | DATA_W | Byte address of the access |
| memWdata | output | DATA_W | Write data |
| memRdata | input | DATA_W | Read data, valid with memAck |
| memAck | input | 1 | Access complete |
| memErr | input | 1 | Access failed, valid with memAck |
| irq | output | 1 | Level interrupt |

## Verification
The copy path is tried with several descriptor shapes:
- **Single terminated descriptor.** Shows that the field order and the word stepping are right.
- **Two-link chain with a byte count that is not a multiple of four, and junk in the low link bits.** Separates partial-word accounting and link masking from the plain case.
- **Zero-count descriptor followed by a real one.** Shows that a null transfer neither touches memory nor breaks the chain.

The stop paths are driven against long descriptors: an abort request, a cleared run bit, and an injected memory error on a write beat. For each, the destination word beyond the stop point shows that the channel went quiet, and the halted and error bits show which path was taken. The interrupt enables are toggled against existing event bits, so that each enable is seen to gate only its own events.

// File: rtl/linkdma_pkg.sv
package linkdma_pkg;

  localparam logic [1:0] REG_CTRL  = 2'd0;
  localparam logic [1:0] REG_STAT  = 2'd1;
  localparam logic [1:0] REG_DPTR  = 2'd2;
  localparam logic [1:0] REG_LEFT  = 2'd3;

  localparam int CTRL_RUN   = 0;
  localparam int CTRL_ABORT = 1;
  localparam int CTRL_ERRIE = 2;
  localparam int CTRL_ENDIE = 3;
  localparam int CTRL_SEGIE = 4;

  localparam int STAT_END  = 0;
  localparam int STAT_SEG  = 1;
  localparam int STAT_BUSY = 2;
  localparam int STAT_HALT = 3;
  localparam int STAT_XERR = 4;
  localparam int STAT_ZERO = 5;

  typedef enum logic [1:0] {
    SEL_DESC,
    SEL_SRC,
    SEL_DST
  } memSel_e;

  typedef struct packed {
    logic       clrHalt;
    logic       setHalt;
    logic       setXferErr;
    logic       setZeroErr;
    logic       setSegDone;
    logic       setChainEnd;
    logic       loadField;
    logic       latchData;
    logic       advance;
    logic       followLink;
    logic [1:0] fieldIdx;
    memSel_e    memSel;
  } dpStrobe_t;

endpackage

// File: rtl/linkdma_ctrl.sv
module linkdma_ctrl
  import linkdma_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startEdge,
  input  logic      stopReq,
  input  logic      cntZero,
  input  logic      cntLast,
  input  logic      termFlag,
  input  logic      memAck,
  input  logic      memErr,
  output dpStrobe_t stb,
  output logic      memReq,
  output logic      memWe,
  output logic      busy
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK,
    ST_READ,
    ST_WRITE,
    ST_LINK
  } state_e;

  state_e     state, stateNxt;
  logic [1:0] fieldIdx, fieldIdxNxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      fieldIdx <= '0;
    end else begin
      state    <= stateNxt;
      fieldIdx <= fieldIdxNxt;
    end
  end

  always_comb begin
    stb          = '0;
    stb.memSel   = SEL_DESC;
    stb.fieldIdx = fieldIdx;
    memReq       = 1'b0;
    memWe        = 1'b0;
    stateNxt     = state;
    fieldIdxNxt  = fieldIdx;

    if (state != ST_IDLE && stopReq) begin
      stb.setHalt = 1'b1;
      stateNxt    = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startEdge && !stopReq) begin
            stb.clrHalt = 1'b1;
            fieldIdxNxt = '0;
            stateNxt    = ST_FETCH;
          end
        end
        ST_FETCH: begin
          memReq = 1'b1;
          if (memAck) begin
            if (memErr) begin
              stb.setXferErr = 1'b1;
              stb.setHalt    = 1'b1;
              stateNxt       = ST_IDLE;
            end else begin
              stb.loadField = 1'b1;
              if (fieldIdx == 2'd3) stateNxt = ST_CHECK;
              else fieldIdxNxt = fieldIdx + 2'd1;
            end
          end
        end
        ST_CHECK: begin
          if (cntZero) begin
            stb.setZeroErr = 1'b1;
            stateNxt       = ST_LINK;
          end else begin
            stateNxt = ST_READ;
          end
        end
        ST_READ: begin
          memReq     = 1'b1;
          stb.memSel = SEL_SRC;
          if (memAck) begin
            if (memErr) begin
              stb.setXferErr = 1'b1;
              stb.setHalt    = 1'b1;
              stateNxt       = ST_IDLE;
            end else begin
              stb.latchData = 1'b1;
              stateNxt      = ST_WRITE;
            end
          end
        end
        ST_WRITE: begin
          memReq     = 1'b1;
          memWe      = 1'b1;
          stb.memSel = SEL_DST;
          if (memAck) begin
            if (memErr) begin
              stb.setXferErr = 1'b1;
              stb.setHalt    = 1'b1;
              stateNxt       = ST_IDLE;
            end else begin
              stb.advance = 1'b1;
              stateNxt    = cntLast ? ST_LINK : ST_READ;
            end
          end
        end
        ST_LINK: begin
          stb.setSegDone = 1'b1;
          if (termFlag) begin
            stb.setChainEnd = 1'b1;
            stateNxt        = ST_IDLE;
          end else begin
            stb.followLink = 1'b1;
            fieldIdxNxt    = '0;
            stateNxt       = ST_FETCH;
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/linkdma_dpath.sv
module linkdma_dpath
  import linkdma_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 26,
  parameter int DESC_ALIGN = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  dpStrobe_t         stb,
  input  logic              busy,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              startEdge,
  output logic              stopReq,
  output logic              cntZero,
  output logic              cntLast,
  output logic              termFlag,
  output logic              irq
);

  localparam int BYTES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(BYTES);
  localparam int BASE_W = DATA_W - DESC_ALIGN;

  logic              runBit, runPrev, errIe, endIe, segIe;
  logic [BASE_W-1:0] descBase;
  logic [CNT_W-1:0]  bytesLeft, stepBytes;
  logic [DATA_W-1:0] srcPtr, dstPtr, linkWord, dataBuf;
  logic              termQ;
  logic              stEnd, stSeg, stXerr, stZero, halted;
  logic              wrCtrl, wrStat, wrDptr, abortReq;

  assign wrCtrl   = regWrEn && (regAddr == REG_CTRL);
  assign wrStat   = regWrEn && (regAddr == REG_STAT);
  assign wrDptr   = regWrEn && (regAddr == REG_DPTR) && !busy;
  assign abortReq = wrCtrl && regWrData[CTRL_ABORT];

  // control word and launch edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runBit  <= 1'b0;
      runPrev <= 1'b0;
      errIe   <= 1'b0;
      endIe   <= 1'b0;
      segIe   <= 1'b0;
    end else begin
      runPrev <= runBit;
      if (wrCtrl) begin
        runBit <= regWrData[CTRL_RUN];
        errIe  <= regWrData[CTRL_ERRIE];
        endIe  <= regWrData[CTRL_ENDIE];
        segIe  <= regWrData[CTRL_SEGIE];
      end
    end
  end

  assign startEdge = runBit && !runPrev;
  assign stopReq   = !runBit || abortReq;

  // descriptor pointer and working registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      descBase  <= '0;
      bytesLeft <= '0;
      srcPtr    <= '0;
      dstPtr    <= '0;
      linkWord  <= '0;
      termQ     <= 1'b0;
      dataBuf   <= '0;
    end else begin
      if (wrDptr) descBase <= regWrData[DATA_W-1:DESC_ALIGN];
      else if (stb.followLink) descBase <= linkWord[DATA_W-1:DESC_ALIGN];
      if (stb.loadField) begin
        case (stb.fieldIdx)
          2'd0: bytesLeft <= memRdata[CNT_W-1:0];
          2'd1: srcPtr    <= memRdata;
          2'd2: dstPtr    <= memRdata;
          default: begin
            linkWord <= memRdata;
            termQ    <= memRdata[0];
          end
        endcase
      end
      if (stb.latchData) dataBuf <= memRdata;
      if (stb.advance) begin
        bytesLeft <= bytesLeft - stepBytes;
        srcPtr    <= srcPtr + DATA_W'(BYTES);
        dstPtr    <= dstPtr + DATA_W'(BYTES);
      end
    end
  end

  assign cntZero   = (bytesLeft == '0);
  assign cntLast   = (bytesLeft <= CNT_W'(BYTES));
  assign stepBytes = cntLast ? bytesLeft : CNT_W'(BYTES);
  assign termFlag  = termQ;

  // status: events set by the sequencer win over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stEnd  <= 1'b0;
      stSeg  <= 1'b0;
      stXerr <= 1'b0;
      stZero <= 1'b0;
      halted <= 1'b0;
    end else begin
      stEnd  <= stb.setChainEnd | (stEnd  & ~(wrStat & regWrData[STAT_END]));
      stSeg  <= stb.setSegDone  | (stSeg  & ~(wrStat & regWrData[STAT_SEG]));
      stXerr <= stb.setXferErr  | (stXerr & ~(wrStat & regWrData[STAT_XERR]));
      stZero <= stb.setZeroErr  | (stZero & ~(wrStat & regWrData[STAT_ZERO]));
      if (stb.setHalt) halted <= 1'b1;
      else if (stb.clrHalt) halted <= 1'b0;
    end
  end

  assign irq = (errIe & (stXerr | stZero)) | (endIe & stEnd) | (segIe & stSeg);

  // memory address select
  always_comb begin
    case (stb.memSel)
      SEL_SRC: memAddr = srcPtr;
      SEL_DST: memAddr = dstPtr;
      default: memAddr = {descBase, {DESC_ALIGN{1'b0}}} + (DATA_W'(stb.fieldIdx) << OFF_W);
    endcase
  end
  assign memWdata = dataBuf;

  // register read mux
  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_CTRL: begin
        regRdData[CTRL_RUN]   = runBit;
        regRdData[CTRL_ERRIE] = errIe;
        regRdData[CTRL_ENDIE] = endIe;
        regRdData[CTRL_SEGIE] = segIe;
      end
      REG_STAT: begin
        regRdData[STAT_END]  = stEnd;
        regRdData[STAT_SEG]  = stSeg;
        regRdData[STAT_BUSY] = busy;
        regRdData[STAT_HALT] = halted;
        regRdData[STAT_XERR] = stXerr;
        regRdData[STAT_ZERO] = stZero;
      end
      REG_DPTR: regRdData = {descBase, {DESC_ALIGN{1'b0}}};
      default:  regRdData = DATA_W'(bytesLeft);
    endcase
  end

endmodule

// File: rtl/linkdma_chan.sv
module linkdma_chan
  import linkdma_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 26,
  parameter int DESC_ALIGN = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              memReq,
  output logic              memWe,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  input  logic              memErr,
  output logic              irq
);

  dpStrobe_t stb;
  logic      busy, startEdge, stopReq, cntZero, cntLast, termFlag;

  linkdma_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startEdge(startEdge), .stopReq(stopReq),
    .cntZero(cntZero), .cntLast(cntLast), .termFlag(termFlag),
    .memAck(memAck), .memErr(memErr), .stb(stb),
    .memReq(memReq), .memWe(memWe), .busy(busy)
  );

  linkdma_dpath #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DESC_ALIGN(DESC_ALIGN)) uDpath (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .stb(stb), .busy(busy),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .startEdge(startEdge), .stopReq(stopReq), .cntZero(cntZero),
    .cntLast(cntLast), .termFlag(termFlag), .irq(irq)
  );

endmodule

// File: rtl/linkdma_chan_chk.sv
module linkdma_chan_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [1:0]        regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic              memReq,
  input logic              memAck,
  input logic              memErr,
  input logic [DATA_W-1:0] memAddr,
  input logic              busy
);

  logic runShadow;
  logic ctrlWr;
  assign ctrlWr = regWrEn && (regAddr == 2'd0);

  always_ff @(posedge clk) begin
    if (!rstN) runShadow <= 1'b0;
    else if (ctrlWr) runShadow <= regWrData[0];
  end

  // R2: a 0-to-1 run write on an idle channel starts it two edges later
  p_launch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && regWrData[0] && !regWrData[1] && !runShadow && !busy) |=> ##1 busy);

  // R3: an unanswered request keeps its address
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && busy && !ctrlWr) |=> (!memReq || $stable(memAddr)));

  // R6: an errored access leaves the channel idle
  p_err_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && memErr) |=> !busy);

  // R7: abort request stops at once
  p_abort_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && regWrData[1]) |=> !busy);

  // R7: dropping the run bit stops within two edges
  p_drop_run_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ctrlWr && !regWrData[0]) |=> ##1 !busy);

endmodule

bind linkdma_chan linkdma_chan_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .memReq(memReq), .memAck(memAck), .memErr(memErr),
  .memAddr(memAddr), .busy(busy)
);

// File: tb/linkdma_chan_test.sv
`timescale 1ns/1ps
module linkdma_chan_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memReq, memWe, irq;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;
  logic        memErr = 1'b0;

  logic [31:0] mem [0:255];
  logic [31:0] errAddr = 32'hFFFF_FFFF;
  logic        tbWe = 1'b0;
  logic [7:0]  tbIdx = '0;
  logic [31:0] tbData = '0;
  int          accCnt = 0;
  int          testCnt = 0;
  int          failCnt = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  linkdma_chan uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck), .memErr(memErr), .irq(irq)
  );

  // memory model: one-cycle registered acknowledge
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 32'hA500_0000 | i;
      memAck <= 1'b0;
      memErr <= 1'b0;
    end else begin
      if (tbWe) mem[tbIdx] <= tbData;
      if (memReq && !memAck) begin
        memAck <= 1'b1;
        memErr <= (memAddr == errAddr);
        accCnt <= accCnt + 1;
        memRdata <= mem[memAddr[9:2]];
        if (memWe && memAddr != errAddr) mem[memAddr[9:2]] <= memWdata;
      end else begin
        memAck <= 1'b0;
        memErr <= 1'b0;
      end
    end
  end

  function automatic logic [31:0] init(input int i);
    return 32'hA500_0000 | i;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic poke(input int addr, input logic [31:0] d);
    @(negedge clk);
    tbWe = 1'b1; tbIdx = addr[9:2]; tbData = d;
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  task automatic putDesc(input int at, input int cnt, input int src, input int dst, input int nxt);
    poke(at, cnt);
    poke(at + 4, src);
    poke(at + 8, dst);
    poke(at + 12, nxt);
  endtask

  task automatic launch(input int at, input logic [31:0] ctrl);
    writeReg(2'd0, 32'h0);
    writeReg(2'd2, at);
    writeReg(2'd0, ctrl);
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3000; k++) begin
      readReg(2'd1, s);
      if (!s[2]) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    readReg(2'd1, d); check("R8 status after reset", d, 32'h0);
    readReg(2'd0, d); check("R2 control after reset", d, 32'h0);
    readReg(2'd3, d); check("R3 count after reset", d, 32'h0);
    check("R9 irq after reset", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_single();
    logic [31:0] d;
    int a;
    putDesc(32'h000, 16, 32'h200, 32'h300, 32'h1);
    launch(32'h000, 32'h1);
    waitIdle();
    for (int k = 0; k < 4; k++) check("R1 R3 single copy", mem[192 + k], init(128 + k));
    check("R3 no overrun", mem[196], init(196));
    readReg(2'd1, d); check("R4 chain end status", d, 32'h03);
    readReg(2'd3, d); check("R3 count reads zero", d, 32'h0);
    readReg(2'd0, d); check("R2 run bit kept", d, 32'h1);
    // R2: rewriting run=1 must not relaunch
    a = accCnt;
    writeReg(2'd0, 32'h1);
    repeat (20) @(negedge clk);
    check("R2 no relaunch accesses", accCnt, a);
    readReg(2'd1, d); check("R2 still idle", d & 32'h4, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    writeReg(2'd1, 32'h01);
    readReg(2'd1, d); check("R8 clear end bit only", d, 32'h02);
    writeReg(2'd1, 32'h0E);
    readReg(2'd1, d); check("R8 clear seg bit", d, 32'h00);
  endtask

  task automatic t_chain();
    logic [31:0] d;
    putDesc(32'h020, 6, 32'h220, 32'h320, 32'h05E);
    putDesc(32'h040, 8, 32'h240, 32'h340, 32'h1);
    launch(32'h020, 32'h1);
    waitIdle();
    check("R3 partial first word", mem[200], init(136));
    check("R3 partial second word", mem[201], init(137));
    check("R3 partial stops", mem[202], init(202));
    check("R4 R1 linked copy a", mem[208], init(144));
    check("R4 R1 linked copy b", mem[209], init(145));
    check("R4 linked no overrun", mem[210], init(210));
    readReg(2'd1, d); check("R4 chain status", d, 32'h03);
    readReg(2'd2, d); check("R10 pointer at last", d, 32'h040);
    writeReg(2'd1, 32'h3F);
  endtask

  task automatic t_zero();
    logic [31:0] d;
    putDesc(32'h060, 0, 32'h260, 32'h360, 32'h080);
    putDesc(32'h080, 4, 32'h280, 32'h380, 32'h1);
    launch(32'h060, 32'h1);
    waitIdle();
    check("R5 null no write", mem[216], init(216));
    check("R5 chain continues", mem[224], init(160));
    readReg(2'd1, d); check("R5 zero error status", d, 32'h23);
    readReg(2'd3, d); check("R5 count zero", d, 32'h0);
    check("R9 irq masked", {31'h0, irq}, 32'h0);
    writeReg(2'd0, 32'h05);
    check("R9 error enable", {31'h0, irq}, 32'h1);
    writeReg(2'd1, 32'h20);
    check("R9 cleared error", {31'h0, irq}, 32'h0);
    writeReg(2'd0, 32'h09);
    check("R9 end enable", {31'h0, irq}, 32'h1);
    writeReg(2'd0, 32'h11);
    check("R9 segment enable", {31'h0, irq}, 32'h1);
    writeReg(2'd1, 32'h03);
    check("R9 all cleared", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_memerr();
    logic [31:0] d;
    putDesc(32'h0A0, 16, 32'h2A0, 32'h3A0, 32'h1);
    errAddr = 32'h3A4;
    launch(32'h0A0, 32'h05);
    waitIdle();
    errAddr = 32'hFFFF_FFFF;
    readReg(2'd1, d); check("R6 error and halt", d, 32'h18);
    check("R6 first word done", mem[232], init(168));
    check("R6 stopped after error", mem[234], init(234));
    check("R9 error irq", {31'h0, irq}, 32'h1);
    writeReg(2'd1, 32'h3F);
    launch(32'h000, 32'h1);
    waitIdle();
    readReg(2'd1, d); check("R8 halt cleared on launch", d, 32'h03);
    writeReg(2'd1, 32'h3F);
  endtask

  task automatic t_abort();
    logic [31:0] d;
    int a;
    putDesc(32'h0C0, 64, 32'h200, 32'h300, 32'h1);
    launch(32'h0C0, 32'h1);
    repeat (20) @(negedge clk);
    writeReg(2'd0, 32'h3);
    readReg(2'd1, d); check("R7 abort halts", d & 32'h0C, 32'h08);
    readReg(2'd0, d); check("R7 abort reads zero", d, 32'h1);
    a = accCnt;
    repeat (20) @(negedge clk);
    check("R7 quiet after abort", accCnt, a);
    check("R7 tail untouched", mem[207], init(207));
    writeReg(2'd1, 32'h3F);
    launch(32'h0C0, 32'h1);
    repeat (20) @(negedge clk);
    writeReg(2'd0, 32'h0);
    repeat (2) @(negedge clk);
    readReg(2'd1, d); check("R7 run drop halts", d & 32'h0C, 32'h08);
    check("R7 tail untouched drop", mem[207], init(207));
  endtask

  task automatic t_pointer();
    logic [31:0] d;
    writeReg(2'd2, 32'h0FF);
    readReg(2'd2, d); check("R10 low bits zero", d, 32'h0E0);
    launch(32'h0C0, 32'h1);
    repeat (5) @(negedge clk);
    writeReg(2'd2, 32'h020);
    writeReg(2'd0, 32'h3);
    readReg(2'd2, d); check("R10 write ignored busy", d, 32'h0C0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_w1c();
    t_chain();
    t_zero();
    t_memerr();
    t_abort();
    t_pointer();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule